// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is a serial-output shift register with a parameterised number of stages (eight by default). On each enabled rising clock edge it does one of two things, chosen by a mode select. It either loads all stages at once from a parallel input word, or it shifts one bit in from a serial input, moving every stage one place towards the output. Only the last stage leaves the block as the serial output. A typical use is to capture a word and then stream it out most-significant stage first.

The clock-gating input is built as a synchronous enable, so the design has no gated clock net. The gating input is only allowed to rise while the clock is high. A monitor checks this rule and keeps a sticky flag when the input rises during the low phase. An asynchronous active-low clear overrides everything else: it empties the register and clears the flag without waiting for a clock edge. A debug port shows the stage contents so the bench can observe them. No functional path uses it.

Top module: `psr_shift_reg`

## Requirements
- R1: While `clr_n` is low, all stages and `inh_violation` are 0 at once, with no clock edge needed, and this overrides every other input.
- R2: Stage contents change only on a rising edge of `clk`. A change on the data or mode inputs during the low phase of the clock has no effect until the next rising edge.
- R3: When `clk_inhibit` is 0 and `shift_nload` is 1, a rising edge moves `ser_in` into stage 0 and moves each stage i (i ≥ 1) to the value that stage i-1 held before the edge.
- R4: When `clk_inhibit` is 0 and `shift_nload` is 0, a rising edge copies `par_in[i]` into stage i for every i. The load is synchronous and does not pass inputs through between edges.
- R5: When `clk_inhibit` is 1, every stage holds its value across rising edges, whatever `shift_nload`, `ser_in` and `par_in` are.
- R6: `par_in[0]` feeds the first stage and `par_in[N-1]` feeds the last stage. `ser_out` is the last stage. After a load, `ser_out` shows `par_in[N-1]` at once. Each later enabled shift edge then shows `par_in[N-2]`, `par_in[N-3]` and so on down to `par_in[0]`.
- R7: If `clk_inhibit` is 0 at a falling edge of `clk` and is 1 at the next rising edge (that is, it rose while the clock was low), `inh_violation` becomes 1 on that rising edge. A rise while the clock is high never sets it.
- R8: Once `inh_violation` is set it stays 1 through any further clock activity. Only `clr_n` low clears it.
- R9: `dbg_stages[i]` shows stage i, where stage 0 is the first stage and stage N-1 drives `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_in | input | 1 | Serial data entering stage 0 in shift mode |
| par_in | input | N | Parallel load word; bit i goes to stage i |
| shift_nload | input | 1 | 1 = shift, 0 = parallel load |
| clk_inhibit | input | 1 | 1 = hold all stages (clock disabled) |
| ser_out | output | 1 | Value of the last stage |
| inh_violation | output | 1 | Sticky flag: inhibit rose while the clock was low |
| dbg_stages | output | N | Debug view of every stage, bit i = stage i |

## Verification
Loads, shifts and holds all take effect on the first rising edge after the inputs are applied, because each stage is a single register. The bench therefore drives inputs 1 ns after a rising edge and checks both the stages and `ser_out` 1 ns after the following rising edge. The violation flag has the same one-edge delay, counted from the falling edge that samples the inhibit. It is checked once before that edge, where it must still be 0, and once after, where it must be 1. The clear acts with zero cycles of delay, so it is checked between clock edges right after `clr_n` falls. Input changes in the clock's low phase are checked just before the next edge, where they must have had no effect yet.

// File: rtl/psr_pkg.sv
// Package: shared operation encoding for the shift register.
package psr_pkg;
    // Operation chosen for the next rising edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2
    } psr_op_e;
endpackage

// File: rtl/psr_ctrl.sv
// psr_ctrl: decodes the inhibit and mode inputs into one operation.
// Assumes: inhibit takes priority over the mode select; purely combinational.
module psr_ctrl
    import psr_pkg::*;
(
    input  logic    clk_inhibit,
    input  logic    shift_nload,
    output psr_op_e op
);
    // Pick hold, shift or load for the coming edge
    always_comb begin
        if (clk_inhibit)
            op = OP_HOLD;
        else if (shift_nload)
            op = OP_SHIFT;
        else
            op = OP_LOAD;
    end
endmodule

// File: rtl/psr_stage.sv
// psr_stage: one register stage with asynchronous active-low clear.
// Assumes: prev_bit is the previous stage (or serial input), load_bit the parallel bit.
module psr_stage
    import psr_pkg::*;
(
    input  logic    clk,
    input  logic    clr_n,
    input  psr_op_e op,
    input  logic    prev_bit,
    input  logic    load_bit,
    output logic    q
);
    logic d;

    // Next-value selection for this stage
    always_comb begin
        unique case (op)
            OP_SHIFT: d = prev_bit;
            OP_LOAD:  d = load_bit;
            default:  d = q;
        endcase
    end

    // Storage flop, cleared asynchronously
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= 1'b0;
        else
            q <= d;
    end
endmodule

// File: rtl/psr_inh_mon.sv
// psr_inh_mon: flags an inhibit rise that happened during the clock low phase.
// Assumes: the inhibit level is sampled at each falling edge; a 1 at a rising
// edge after a 0 at the preceding falling edge means it rose while clk was low.
module psr_inh_mon (
    input  logic clk,
    input  logic clr_n,
    input  logic clk_inhibit,
    output logic violation
);
    logic inh_at_fall;

    // Capture inhibit level at the start of the low phase (reset to 1: no false flag)
    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n)
            inh_at_fall <= 1'b1;
        else
            inh_at_fall <= clk_inhibit;
    end

    // Sticky violation flag, cleared only by the asynchronous clear
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            violation <= 1'b0;
        else if (clk_inhibit && !inh_at_fall)
            violation <= 1'b1;
    end
endmodule

// File: rtl/psr_shift_reg.sv
// psr_shift_reg: N-stage shift register with parallel load, serial output,
// synchronous clock-enable inhibit and an inhibit-timing monitor.
// Assumes: a single clock domain; clr_n is asynchronous and overrides all inputs.
module psr_shift_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         ser_in,
    input  logic [N-1:0] par_in,
    input  logic         shift_nload,
    input  logic         clk_inhibit,
    output logic         ser_out,
    output logic         inh_violation,
    output logic [N-1:0] dbg_stages
);
    import psr_pkg::*;

    localparam int LAST = N - 1;

    psr_op_e      op;
    logic [N-1:0] stage_q;

    psr_ctrl u_ctrl (
        .clk_inhibit (clk_inhibit),
        .shift_nload (shift_nload),
        .op          (op)
    );

    // Chain of stages: stage 0 takes ser_in, stage i takes stage i-1
    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_first
            psr_stage u_stage (
                .clk      (clk),
                .clr_n    (clr_n),
                .op       (op),
                .prev_bit (ser_in),
                .load_bit (par_in[i]),
                .q        (stage_q[i])
            );
        end else begin : g_next
            psr_stage u_stage (
                .clk      (clk),
                .clr_n    (clr_n),
                .op       (op),
                .prev_bit (stage_q[i-1]),
                .load_bit (par_in[i]),
                .q        (stage_q[i])
            );
        end
    end

    psr_inh_mon u_mon (
        .clk         (clk),
        .clr_n       (clr_n),
        .clk_inhibit (clk_inhibit),
        .violation   (inh_violation)
    );

    // Output wiring: only the last stage is the functional output
    always_comb begin
        ser_out    = stage_q[LAST];
        dbg_stages = stage_q;
    end
endmodule

// File: rtl/psr_shift_reg_chk.sv
// psr_shift_reg_chk: property checker bound to psr_shift_reg.
module psr_shift_reg_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         clr_n,
    input logic         ser_in,
    input logic [N-1:0] par_in,
    input logic         shift_nload,
    input logic         clk_inhibit,
    input logic         ser_out,
    input logic         inh_violation,
    input logic [N-1:0] dbg_stages
);
    // R1
    clear_state_chk: assert property (@(posedge clk)
        !clr_n |-> (dbg_stages == '0 && !inh_violation));

    // R3
    shift_move_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_inhibit && shift_nload) |=>
            dbg_stages == {$past(dbg_stages[N-2:0]), $past(ser_in)});

    // R4
    load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_inhibit && !shift_nload) |=> dbg_stages == $past(par_in));

    // R5
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        clk_inhibit |=> $stable(dbg_stages));

    // R6
    load_out_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (!clk_inhibit && !shift_nload) |=> ser_out == $past(par_in[N-1]));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!clr_n)
        inh_violation |=> inh_violation);
endmodule

bind psr_shift_reg psr_shift_reg_chk #(.N(N)) u_chk (
    .clk           (clk),
    .clr_n         (clr_n),
    .ser_in        (ser_in),
    .par_in        (par_in),
    .shift_nload   (shift_nload),
    .clk_inhibit   (clk_inhibit),
    .ser_out       (ser_out),
    .inh_violation (inh_violation),
    .dbg_stages    (dbg_stages)
);

// File: tb/psr_shift_reg_tb.sv
`timescale 1ns/1ps
module psr_shift_reg_tb;
    localparam int N = 8;
    localparam int NVEC = 10;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         ser_in = 1'b0;
    logic [N-1:0] par_in = '0;
    logic         shift_nload = 1'b1;
    logic         clk_inhibit = 1'b0;
    logic         ser_out;
    logic         inh_violation;
    logic [N-1:0] dbg_stages;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    psr_shift_reg #(.N(N)) u_dut (
        .clk           (clk),
        .clr_n         (clr_n),
        .ser_in        (ser_in),
        .par_in        (par_in),
        .shift_nload   (shift_nload),
        .clk_inhibit   (clk_inhibit),
        .ser_out       (ser_out),
        .inh_violation (inh_violation),
        .dbg_stages    (dbg_stages)
    );

    // Vector: {shift_nload, clk_inhibit, ser_in, par_in, expected stages}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},   // R4 load
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h4B},   // R3 shift in 1
        {1'b1, 1'b0, 1'b0, 8'hFF, 8'h96},   // R3 shift in 0
        {1'b0, 1'b1, 1'b0, 8'hFF, 8'h96},   // R5 hold vs load
        {1'b1, 1'b1, 1'b1, 8'h00, 8'h96},   // R5 hold vs shift
        {1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C},   // R4 load
        {1'b1, 1'b0, 1'b1, 8'hC3, 8'h79},   // R3
        {1'b1, 1'b0, 1'b1, 8'h00, 8'hF3},   // R3
        {1'b0, 1'b0, 1'b1, 8'h00, 8'h00},   // R4 load zero
        {1'b1, 1'b0, 1'b1, 8'hFF, 8'h01}    // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic after_rise();
        @(posedge clk);
        #1;
    endtask

    task automatic do_load(input logic [N-1:0] w);
        shift_nload = 1'b0; clk_inhibit = 1'b0; par_in = w;
        after_rise();
    endtask

    initial begin : watchdog
        #(200000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [N-1:0] w;
        #1 clr_n = 1'b0;
        after_rise();
        // R1 reset state
        chk("R1 reset stages", dbg_stages, 0);
        chk("R1 reset flag", inh_violation, 0);
        chk("R6 reset ser_out", ser_out, 0);
        clr_n = 1'b1;

        // Table walk: drive after an edge, check after the next edge
        for (int k = 0; k < NVEC; k++) begin
            {shift_nload, clk_inhibit, ser_in, par_in} = VEC[k][18:8];
            after_rise();
            chk("R3/R4/R5/R9 stages", dbg_stages, VEC[k][7:0]);
            chk("R6 ser_out last stage", ser_out, VEC[k][7]);
            chk("R7 no flag on legal inhibit", inh_violation, 0);
        end

        // R2: change during low phase has no effect until the rising edge
        do_load(8'h81);
        shift_nload = 1'b1; clk_inhibit = 1'b1;
        @(negedge clk); #0.5;
        shift_nload = 1'b0; par_in = 8'hF0;
        // keep inhibit high (lowering is always legal) only via load below
        clk_inhibit = 1'b0;
        #1;
        chk("R2 no change before edge", dbg_stages, 8'h81);
        after_rise();
        chk("R2 change at edge", dbg_stages, 8'hF0);

        // R6: output order after a load
        w = 8'hB4;
        do_load(w);
        chk("R6 first bit", ser_out, w[7]);
        shift_nload = 1'b1; ser_in = 1'b0;
        for (int b = N - 2; b >= 0; b--) begin
            after_rise();
            chk("R6 serial order", ser_out, w[b]);
        end

        // R7: legal rise while clock high sets nothing
        clk_inhibit = 1'b1;
        after_rise();
        after_rise();
        chk("R7 legal rise no flag", inh_violation, 0);
        clk_inhibit = 1'b0;
        after_rise();

        // R7: rise while clock low sets the flag at the next rising edge
        @(negedge clk); #1;
        clk_inhibit = 1'b1;
        #0.5;
        chk("R7 flag before edge", inh_violation, 0);
        after_rise();
        chk("R7 flag after illegal rise", inh_violation, 1);

        // R8: sticky through further activity
        do_load(8'h5A);
        clk_inhibit = 1'b0; shift_nload = 1'b1;
        after_rise();
        after_rise();
        chk("R8 flag sticky", inh_violation, 1);
        chk("R3 shift after flag", dbg_stages, 8'h68);

        // R1/R8: asynchronous clear between edges
        do_load(8'hFF);
        clr_n = 1'b0;
        #0.5;
        chk("R1 async clear stages", dbg_stages, 0);
        chk("R8 clear resets flag", inh_violation, 0);
        chk("R1 async clear ser_out", ser_out, 0);
        after_rise();
        chk("R1 clear overrides load", dbg_stages, 0);
        clr_n = 1'b1;
        after_rise();
        chk("R4 load after clear", dbg_stages, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule